// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets an external host read and write a bank of 8-bit registers over a serial link made of a clock (SPC), an active-low chip select and one or two data lines. It runs entirely on the system clock. The three serial inputs pass through a synchroniser, and the block finds the SPC edges by comparing successive synchronised samples. Each frame starts with one direction bit and a 7-bit register address, both sent MSB first. One or more data bytes follow.

Two registers live inside the block. The first is a fixed identity register. The second is a control register that selects the wire mode and turns address auto-increment on or off. Every other address is passed to an external register file through a plain address / write-data / write-strobe / read-data port. In 4-wire mode read data leaves on a dedicated output, qualified by `sdo_en_o`. In 3-wire mode the same data is driven onto the shared data line, qualified by `sdio_en_o`; the pad outside the block does the turnaround.

Top module: `spirb_slave`

## Requirements
- R1: The block samples the data input on each rising SPC edge while CS is low. The first eight bits form the header: direction (1 = read, 0 = write), then address bits 6 down to 0. Each following group of eight bits is one data byte, MSB first.
- R2: Each fully received write byte to an external address produces exactly one single-cycle `rf_we_o` pulse, with that byte on `rf_wdata_o` and the target address on `rf_addr_o`.
- R3: On a read, the byte at the current address goes out MSB first. The output changes on falling SPC edges, starting with the falling edge that begins bit 8.
- R4: A burst adds one byte for every further 8 SPC clocks. With auto-increment on, the address advances by one after each data byte. With it off, every byte of the burst uses the header address.
- R5: Auto-increment wraps from address 7Fh to 00h.
- R6: Address 0Fh always reads 69h. Writes to it cause no `rf_we_o` pulse and do not change the value read back.
- R7: Address 12h is the internal control register and resets to 00h. Bit 0 selects 3-wire mode when 1. Bit 1 enables auto-increment when 1. The other bits always read 0. Writing it causes no `rf_we_o` pulse.
- R8: In 4-wire mode, read data is qualified by `sdo_en_o`, and `sdio_en_o` stays low.
- R9: In 3-wire mode, read data is qualified by `sdio_en_o` during the data bits, and `sdo_en_o` stays low.
- R10: While CS is high, the bit position returns to the frame start and both output enables are low.
- R11: A frame that CS ends part-way through a byte writes nothing, and the next frame is framed from its own first bit.
- R12: After reset both output enables are low and `rf_we_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spc_i | input | 1 | Serial clock from host, idle high |
| cs_n_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in; in 3-wire mode the shared line as seen at the pad |
| dout_o | output | 1 | Serial read data bit |
| sdo_en_o | output | 1 | Drive enable for the separate output line (4-wire) |
| sdio_en_o | output | 1 | Drive enable for the shared line (3-wire) |
| rf_addr_o | output | 7 | Register file address |
| rf_wdata_o | output | 8 | Register file write data |
| rf_we_o | output | 1 | Register file write strobe, one cycle |
| rf_rdata_i | input | 8 | Register file read data at `rf_addr_o` |

## Verification
Single-byte writes and reads go to scattered addresses, including 7Fh and the identity address. Each write is followed by a read back, which separates correct address framing from bit-order or shift-length errors. Bursts are run with auto-increment both on and off, starting at 7Eh, so the wrap to 00h and the overwrite of one fixed address show up as different contents in the register file. An aborted partial write, an attempted identity write and control-register writes show that protected addresses and incomplete bytes leave state unchanged. Reads in both wire modes show which enable qualifies the data.

// File: rtl/spirb_pkg.sv
package spirb_pkg;
   typedef struct packed {
      logic auto_inc;
      logic three_wire;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/spirb_sync.sv
module spirb_sync #(
   parameter int       STAGES  = 2,
   parameter int       W       = 3,
   parameter bit [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spirb_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_line
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RST_VAL[i]}};
         else        ff <= {ff[STAGES-2:0], d_i[i]};
      end
      assign q_o[i] = ff[STAGES-1];
   end
endmodule

// File: rtl/spirb_edge.sv
module spirb_edge #(
   parameter bit IDLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE;
      else        prev <= lvl_i;
   end

   assign rise_o = lvl_i & ~prev;
   assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/spirb_frame.sv
module spirb_frame #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act_i,
   input  logic              spc_rise_i,
   input  logic              spc_fall_i,
   input  logic              sdi_i,
   input  logic              auto_inc_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              wstb_o,
   output logic              drive_o,
   output logic              dout_o
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  bitc;
   logic              hdr_done;
   logic              rd_mode;
   logic              load_pend;
   logic              inc_pend;
   logic              tx_live;
   logic [DATA_W-1:0] rx;
   logic [DATA_W-1:0] tx;
   logic [DATA_W-1:0] rx_next;
   logic              byte_end;

   assign rx_next  = {rx[DATA_W-2:0], sdi_i};
   assign byte_end = spc_rise_i && (bitc == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitc      <= '0;
         hdr_done  <= 1'b0;
         rd_mode   <= 1'b0;
         load_pend <= 1'b0;
         inc_pend  <= 1'b0;
         tx_live   <= 1'b0;
         rx        <= '0;
         tx        <= '0;
         addr_o    <= '0;
         wdata_o   <= '0;
         wstb_o    <= 1'b0;
      end else begin
         wstb_o   <= 1'b0;
         inc_pend <= 1'b0;
         if (inc_pend) addr_o <= addr_o + 1'b1;
         if (!cs_act_i) begin
            bitc      <= '0;
            hdr_done  <= 1'b0;
            rd_mode   <= 1'b0;
            load_pend <= 1'b0;
            tx_live   <= 1'b0;
         end else begin
            if (spc_rise_i) begin
               rx   <= rx_next;
               bitc <= byte_end ? '0 : bitc + 1'b1;
            end
            if (byte_end) begin
               if (!hdr_done) begin
                  hdr_done  <= 1'b1;
                  rd_mode   <= rx_next[DATA_W-1];
                  addr_o    <= rx_next[ADDR_W-1:0];
                  load_pend <= rx_next[DATA_W-1];
               end else begin
                  if (!rd_mode) begin
                     wstb_o  <= 1'b1;
                     wdata_o <= rx_next;
                  end
                  load_pend <= rd_mode;
                  inc_pend  <= auto_inc_i;
               end
            end
            if (spc_fall_i) begin
               if (load_pend) begin
                  tx        <= rdata_i;
                  load_pend <= 1'b0;
                  tx_live   <= 1'b1;
               end else begin
                  tx <= tx << 1;
               end
            end
         end
      end
   end

   assign drive_o = tx_live;
   assign dout_o  = tx[DATA_W-1];
endmodule

// File: rtl/spirb_slave.sv
module spirb_slave
   import spirb_pkg::*;
#(
   parameter int              ADDR_W      = 7,
   parameter int              DATA_W      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ID_ADDR   = 7'h0F,
   parameter logic [DATA_W-1:0] ID_VALUE  = 8'h69,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spc_i,
   input  logic              cs_n_i,
   input  logic              sdi_i,
   output logic              dout_o,
   output logic              sdo_en_o,
   output logic              sdio_en_o,
   output logic [ADDR_W-1:0] rf_addr_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic              rf_we_o,
   input  logic [DATA_W-1:0] rf_rdata_i
);
   if (DATA_W != ADDR_W + 1) begin : g_bad_frame
      $error("spirb_slave: header must be one direction bit plus the address");
   end
   if ((DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("spirb_slave: DATA_W must be a power of two");
   end
   if (ID_ADDR == CTRL_ADDR) begin : g_bad_map
      $error("spirb_slave: identity and control addresses must differ");
   end

   logic [2:0]        sync_q;
   logic              spc_s, cs_act, sdi_s;
   logic              spc_rise, spc_fall;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] wdata;
   logic              wstb;
   logic              drive;
   logic [DATA_W-1:0] rdata_mux;
   ctrl_t             ctrl;

   spirb_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b110)) sync_i (
      .clk(clk), .rst_n(rst_n),
      .d_i({spc_i, cs_n_i, sdi_i}), .q_o(sync_q)
   );

   assign spc_s  = sync_q[2];
   assign cs_act = ~sync_q[1];
   assign sdi_s  = sync_q[0];

   spirb_edge #(.IDLE(1'b1)) edge_i (
      .clk(clk), .rst_n(rst_n), .lvl_i(spc_s),
      .rise_o(spc_rise), .fall_o(spc_fall)
   );

   spirb_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) frame_i (
      .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act),
      .spc_rise_i(spc_rise), .spc_fall_i(spc_fall), .sdi_i(sdi_s),
      .auto_inc_i(ctrl.auto_inc), .rdata_i(rdata_mux),
      .addr_o(addr), .wdata_o(wdata), .wstb_o(wstb),
      .drive_o(drive), .dout_o(dout_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         ctrl <= '0;
      else if (wstb && addr == CTRL_ADDR) ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
   end

   always_comb begin
      if (addr == ID_ADDR)        rdata_mux = ID_VALUE;
      else if (addr == CTRL_ADDR) rdata_mux = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl};
      else                        rdata_mux = rf_rdata_i;
   end

   assign rf_addr_o  = addr;
   assign rf_wdata_o = wdata;
   assign rf_we_o    = wstb && (addr != ID_ADDR) && (addr != CTRL_ADDR);
   assign sdo_en_o   = drive && !ctrl.three_wire;
   assign sdio_en_o  = drive && ctrl.three_wire;
endmodule

// File: rtl/spirb_slave_chk.sv
module spirb_slave_chk #(
   parameter int              ADDR_W    = 7,
   parameter logic [ADDR_W-1:0] ID_ADDR   = 7'h0F,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 7'h12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              sdo_en_o,
   input logic              sdio_en_o,
   input logic              rf_we_o,
   input logic [ADDR_W-1:0] rf_addr_o
);
   // R10: once CS is seen high, no line is driven
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (!sdo_en_o && !sdio_en_o));

   // R8 / R9: only one of the two drivers is ever enabled
   a_r9_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      !(sdo_en_o && sdio_en_o));

   // R2: write strobe is a single-cycle pulse
   a_r2_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |=> !rf_we_o);

   // R6 / R7: internal addresses never reach the register file
   a_r6_protect: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (rf_addr_o != ID_ADDR && rf_addr_o != CTRL_ADDR));

   // R2: no read driving while a write byte lands
   a_r2_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (!sdo_en_o && !sdio_en_o));
endmodule

bind spirb_slave spirb_slave_chk #(
   .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
   .sdo_en_o(sdo_en_o), .sdio_en_o(sdio_en_o),
   .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o)
);

// File: tb/spirb_slave_tb.sv
module spirb_slave_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spc = 1'b1, cs_n = 1'b1, sdi = 1'b0;
   logic dout, sdo_en, sdio_en, rf_we;
   logic [6:0] rf_addr;
   logic [7:0] rf_wdata, rf_rdata;

   logic [7:0] mem [128];
   int id_we_cnt = 0;
   int total = 0, bad = 0;
   bit done = 1'b0;

   logic [7:0] tx_buf [4];
   logic [7:0] rx_buf [4];
   bit seen_sdo, seen_sdio;

   always #(CLK_PERIOD/2) clk = ~clk;

   spirb_slave dut_i (
      .clk(clk), .rst_n(rst_n), .spc_i(spc), .cs_n_i(cs_n), .sdi_i(sdi),
      .dout_o(dout), .sdo_en_o(sdo_en), .sdio_en_o(sdio_en),
      .rf_addr_o(rf_addr), .rf_wdata_o(rf_wdata), .rf_we_o(rf_we),
      .rf_rdata_i(rf_rdata)
   );

   initial for (int i = 0; i < 128; i++) mem[i] = 8'h00;
   always @(posedge clk) begin
      if (rf_we) begin
         mem[rf_addr] <= rf_wdata;
         if (rf_addr == 7'h0F) id_we_cnt <= id_we_cnt + 1;
      end
   end
   assign rf_rdata = mem[rf_addr];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_xfer(input bit rd, input logic [6:0] addr, input int nbytes);
      logic [7:0] hdr;
      hdr = {rd, addr};
      seen_sdo = 1'b0; seen_sdio = 1'b0;
      cs_n = 1'b0;
      wait_n(HALF);
      for (int b = 7; b >= 0; b--) begin
         spc = 1'b0; sdi = hdr[b];
         wait_n(HALF);
         spc = 1'b1;
         wait_n(HALF);
      end
      for (int k = 0; k < nbytes; k++) begin
         for (int b = 7; b >= 0; b--) begin
            spc = 1'b0;
            sdi = rd ? 1'b0 : tx_buf[k][b];
            wait_n(HALF);
            rx_buf[k][b] = dout;
            if (sdo_en) seen_sdo = 1'b1;
            if (sdio_en) seen_sdio = 1'b1;
            spc = 1'b1;
            wait_n(HALF);
         end
      end
      cs_n = 1'b1;
      wait_n(HALF);
   endtask

   task automatic wr1(input logic [6:0] a, input logic [7:0] d);
      tx_buf[0] = d;
      spi_xfer(1'b0, a, 1);
   endtask

   task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
      spi_xfer(1'b1, a, 1);
      check(rx_buf[0] == exp, req, rx_buf[0], exp);
   endtask

   task automatic report;
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   // {rd, addr[6:0], wdata[7:0], expected[7:0]}
   localparam logic [23:0] VEC [10] = '{
      {1'b0, 7'h20, 8'hA5, 8'h00},
      {1'b1, 7'h20, 8'h00, 8'hA5},
      {1'b0, 7'h05, 8'h3C, 8'h00},
      {1'b1, 7'h05, 8'h00, 8'h3C},
      {1'b1, 7'h0F, 8'h00, 8'h69},
      {1'b0, 7'h0F, 8'h00, 8'h00},
      {1'b1, 7'h0F, 8'h00, 8'h69},
      {1'b0, 7'h7F, 8'h81, 8'h00},
      {1'b1, 7'h7F, 8'h00, 8'h81},
      {1'b1, 7'h20, 8'h00, 8'hA5}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=0 expected=1");
         report();
         $finish;
      end
   end

   initial begin
      wait_n(4);
      check(!sdo_en && !sdio_en, "R12 enables in reset", {sdo_en, sdio_en}, 0);
      rst_n = 1'b1;
      wait_n(4);
      check(!sdo_en && !sdio_en && !rf_we, "R12 idle after reset",
            {sdo_en, sdio_en, rf_we}, 0);
      rd_chk(7'h12, 8'h00, "R7 control reset value");

      // table walk: 4-wire, no auto-increment (R1 R2 R3 R6)
      for (int i = 0; i < 10; i++) begin
         if (VEC[i][23] == 1'b0) wr1(VEC[i][22:16], VEC[i][15:8]);
         else rd_chk(VEC[i][22:16], VEC[i][7:0], "R1 R3 vector read");
      end
      check(mem[7'h20] == 8'hA5, "R2 write landed", mem[7'h20], 8'hA5);
      check(id_we_cnt == 0, "R6 no strobe at identity", id_we_cnt, 0);

      // burst without auto-increment (R4)
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h22;
      spi_xfer(1'b0, 7'h30, 2);
      rd_chk(7'h30, 8'h22, "R4 fixed address burst");
      rd_chk(7'h31, 8'h00, "R4 neighbour untouched");

      // auto-increment with wrap (R4 R5 R7)
      wr1(7'h12, 8'h02);
      check(mem[7'h12] == 8'h00, "R7 control write not forwarded", mem[7'h12], 0);
      rd_chk(7'h12, 8'h02, "R7 control readback");
      tx_buf[0] = 8'h44; tx_buf[1] = 8'h55; tx_buf[2] = 8'h66;
      spi_xfer(1'b0, 7'h7E, 3);
      check(mem[7'h7E] == 8'h44, "R4 burst byte0", mem[7'h7E], 8'h44);
      check(mem[7'h7F] == 8'h55, "R4 burst byte1", mem[7'h7F], 8'h55);
      check(mem[7'h00] == 8'h66, "R5 wrap to zero", mem[7'h00], 8'h66);
      spi_xfer(1'b1, 7'h7E, 3);
      check(rx_buf[0] == 8'h44, "R4 burst read 0", rx_buf[0], 8'h44);
      check(rx_buf[1] == 8'h55, "R4 burst read 1", rx_buf[1], 8'h55);
      check(rx_buf[2] == 8'h66, "R5 burst read wrap", rx_buf[2], 8'h66);
      check(seen_sdo && !seen_sdio, "R8 4-wire driver", {seen_sdo, seen_sdio}, 2);

      // aborted write (R10 R11)
      cs_n = 1'b0;
      wait_n(HALF);
      for (int b = 0; b < 12; b++) begin
         spc = 1'b0;
         sdi = (b == 1 || b == 7 || b > 8) ? 1'b1 : 1'b0;
         wait_n(HALF);
         spc = 1'b1;
         wait_n(HALF);
      end
      cs_n = 1'b1;
      wait_n(HALF);
      check(!sdo_en && !sdio_en, "R10 released with CS high", {sdo_en, sdio_en}, 0);
      check(mem[7'h41] == 8'h00, "R11 aborted write dropped", mem[7'h41], 0);
      wr1(7'h42, 8'h5A);
      check(mem[7'h42] == 8'h5A, "R10 reframed after abort", mem[7'h42], 8'h5A);

      // 3-wire mode (R7 R9)
      wr1(7'h12, 8'hFF);
      rd_chk(7'h12, 8'h03, "R7 unused bits read zero");
      check(seen_sdio && !seen_sdo, "R9 3-wire driver", {seen_sdo, seen_sdio}, 1);
      rd_chk(7'h20, 8'hA5, "R9 3-wire read");
      check(seen_sdio && !seen_sdo, "R9 3-wire data line", {seen_sdo, seen_sdio}, 1);
      wr1(7'h12, 8'h00);
      rd_chk(7'h05, 8'h3C, "R8 back to 4-wire");
      check(seen_sdo && !seen_sdio, "R8 4-wire after switch", {seen_sdo, seen_sdio}, 2);

      done = 1'b1;
      report();
      $finish;
   end
endmodule